// File: doc/BRIEF.md
# Adder-Subtractor with Held Status Flags

This block is the arithmetic stage of a small accumulator-style processor. It continuously forms either the sum or the two's-complement difference of two register values, whether or not an arithmetic instruction is running. A subtract control selects the difference by inverting the second operand and forcing a carry-in of one. The result reaches the shared bus only while the output enable is high. At all other times the bus output is held at zero.

Three status signals are derived from the live result: zero, sign and carry. Zero means every result bit is clear. Sign is the top result bit, and no signedness is assumed. Carry is the adder's carry out. A three-bit flag register captures these signals only on a clock edge where the load enable is high. The sequencer raises that enable together with the output enable during a deliberate add or subtract transfer. So the held flags describe the last intended operation, not the free-running adder output that follows it. The held flags are brought out one by one for later conditional branch decisions.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_sel` low and `res_oe` high, `bus_out` equals `(opnd_a + opnd_b) mod 2^WIDTH`, combinationally.
- R2: With `sub_sel` high and `res_oe` high, `bus_out` equals `(opnd_a - opnd_b) mod 2^WIDTH`, combinationally.
- R3: With `res_oe` low, `bus_out` is all zeros, whatever the operands and the operation.
- R4: On a rising edge with `flg_ld` high and `rst` low, `hold_z` becomes 1 exactly when every bit of the live result is 0.
- R5: On such a load edge, `hold_s` takes the most significant bit of the live result.
- R6: On such a load edge, `hold_c` takes the carry out of the adder. For an add this is bit WIDTH of `opnd_a + opnd_b`. For a subtract it is 1 exactly when `opnd_a >= opnd_b` as unsigned values, so 5-5 gives a carry of 1.
- R7: On a rising edge with `flg_ld` low, all three held flags keep their values, whatever the operands, `sub_sel` and `res_oe` do.
- R8: A rising edge with `rst` high clears all three held flags, even when `flg_ld` is also high.
- R9: The held flags change only at a clock edge. After 0 from 5-5 is written back so that the live result becomes 0xFB, the flags still show zero=1, sign=0, carry=1 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears flags |
| opnd_a | input | WIDTH | First operand (accumulator) |
| opnd_b | input | WIDTH | Second operand |
| sub_sel | input | 1 | 1 selects A-B, 0 selects A+B |
| res_oe | input | 1 | Drives the result onto `bus_out` |
| flg_ld | input | 1 | Captures the status signals at the next edge |
| bus_out | output | WIDTH | Result when enabled, else zero |
| hold_z | output | 1 | Held zero flag |
| hold_s | output | 1 | Held sign flag (result MSB) |
| hold_c | output | 1 | Held carry flag |

## Verification
The hardest case to reach is the one where the live status and the held status disagree. The operands must change after a load, so that the free-running result moves away from the captured one while the load enable stays low. A directed sequence reproduces the write-back scenario. It loads 5-5, then presents A=0, B=5 with subtract still selected, and checks both the live bus value 0xFB and the unchanged flags. Seeded random operations then mix load and no-load cycles independently of the output enable. This way many hold cycles follow loads, with operands that would give different flags.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sub_sel,
  input  logic             res_oe,
  input  logic             flg_ld,
  output logic [WIDTH-1:0] bus_out,
  output logic             hold_z,
  output logic             hold_s,
  output logic             hold_c
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_w;
  logic [WIDTH-1:0] result;
  logic             st_z, st_s, st_c;

  assign b_eff  = sub_sel ? ~opnd_b : opnd_b;
  assign sum_w  = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_sel};
  assign result = sum_w[WIDTH-1:0];

  assign st_z = ~|result;
  assign st_s = result[WIDTH-1];
  assign st_c = sum_w[WIDTH];

  assign bus_out = res_oe ? result : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_z <= 1'b0;
      hold_s <= 1'b0;
      hold_c <= 1'b0;
    end else if (flg_ld) begin
      hold_z <= st_z;
      hold_s <= st_s;
      hold_c <= st_c;
    end
  end

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (flg_ld && res_oe) |=> (hold_z == ($past(bus_out) == '0)));

  p_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (flg_ld && res_oe) |=> (hold_s == $past(bus_out[WIDTH-1])));

  p_carry_add_r6: assert property (@(posedge clk) disable iff (rst)
    (flg_ld && !sub_sel) |=>
      (hold_c == $past(((({1'b0, opnd_a} + {1'b0, opnd_b}) >> WIDTH) != '0))));

  p_carry_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (flg_ld && sub_sel) |=> (hold_c == $past(opnd_a >= opnd_b)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !flg_ld |=> $stable({hold_z, hold_s, hold_c}));

  p_clear_r8: assert property (@(posedge clk)
    rst |=> ({hold_z, hold_s, hold_c} == 3'b000));

endmodule

// File: tb/addsub_flags_tb_top.sv
module addsub_flags_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         sub = 1'b0, oe = 1'b0, ld = 1'b0;
  logic [W-1:0] bus;
  logic         hz, hs, hc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic mz = 1'b0, ms = 1'b0, mc = 1'b0;

  always #4 clk = ~clk;

  addsub_flags #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .sub_sel(sub),
    .res_oe(oe), .flg_ld(ld), .bus_out(bus),
    .hold_z(hz), .hold_s(hs), .hold_c(hc)
  );

  function automatic logic [W:0] ref_calc(logic [W-1:0] x, logic [W-1:0] y, logic s);
    logic [W:0] r;
    if (s) begin
      r[W-1:0] = x - y;
      r[W]     = (x >= y);
    end else begin
      r = {1'b0, x} + {1'b0, y};
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [W-1:0] x, logic [W-1:0] y, logic s, logic e, logic l,
                      logic r, string req);
    logic [W:0] rv;
    a = x; b = y; sub = s; oe = e; ld = l; rst = r;
    rv = ref_calc(x, y, s);
    #1;
    if (!e)     chk("R3", bus, '0);
    else if (s) chk("R2", bus, rv[W-1:0]);
    else        chk("R1", bus, rv[W-1:0]);
    @(posedge clk);
    if (r) begin
      mz = 0; ms = 0; mc = 0;
    end else if (l) begin
      mz = (rv[W-1:0] == '0); ms = rv[W-1]; mc = rv[W];
    end
    @(negedge clk);
    chk(req, {5'b0, hz, hs, hc}, {5'b0, mz, ms, mc});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);
    @(negedge clk);
    chk("R8 reset", {5'b0, hz, hs, hc}, 8'h00);
    rst = 1'b0;
    // directed: 5-5 then write-back makes live result 0xFB
    step(8'd5, 8'd5, 1, 1, 1, 0, "R4 R6 5-5");
    chk("R6 c=1 after 5-5", {7'b0, hc}, 8'h01);
    step(8'd0, 8'd5, 1, 1, 0, 0, "R9 hold after writeback");
    chk("R9 live 0xFB", bus, 8'hFB);
    chk("R9 z still 1", {7'b0, hz}, 8'h01);
    step(8'hFF, 8'h01, 0, 1, 1, 0, "R4 R6 wrap add");
    step(8'h7F, 8'h01, 0, 1, 1, 0, "R5 sign add");
    step(8'h03, 8'h04, 1, 1, 1, 0, "R5 R6 borrow");
    step(8'h00, 8'h00, 1, 0, 0, 0, "R7 hold oe off");
    step(8'h80, 8'h80, 0, 1, 1, 1, "R8 reset over load");
    step(8'h00, 8'h00, 0, 1, 1, 0, "R4 zero add");
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x, y;
      logic s, e, l;
      x = W'($urandom());
      y = W'($urandom());
      s = 1'($urandom());
      e = 1'($urandom());
      l = ($urandom_range(0, 2) == 0);
      step(x, y, s, e, l, 0, l ? "R4 R5 R6 load" : "R7 hold");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule